// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Current Regulator

This block is the digital regulation core of a solenoid driver. It receives a sampled 7-bit load-current code and keeps that current inside a hysteresis band. It does this by switching a high-side gate command on and off. Whenever the high-side switch is held off during regulation, a complementary clamp gate command is driven. A fixed dead time separates the two gate commands. Two threshold pairs are held, one for a short high-current peak phase and one for a lower hold phase. A loop-state output reports whether the current is at or above the reference in force.

A configuration bit picks how the peak phase ends. In counting mode, each command start arms an 8-bit dwell count, and rising edges on an external phase pin count it down. In level mode, the phase pin directly picks the pair. A small parallel write port sets the thresholds, the dwell count and the mode. The port carries a 3-bit address and 8 bits of data.

Top module: `ph_regulator`

## Requirements
- R1: After synchronous reset, both gate outputs are low and counting mode is selected. The peak pair is upper 100 / lower 90, the hold pair is upper 40 / lower 30, and the dwell count is 4. The peak pair is selected and loop_o is 0 with a current code of 0.
- R2: Gate outputs can be high only while en_i and ctrl_i are both high. Dropping either one forces both gates low in the same cycle, with no clock edge needed.
- R3: While commanded, a current code at or above the active upper level turns the high-side request off at the next clock edge. A code below the active lower level turns it back on. A code between the levels leaves the request unchanged. The upper check wins if both hold.
- R4: loop_o is 1 exactly when the current code is at or above the reference. The reference is the active upper level while the high-side request is on, and the active lower level while it is off.
- R5: While commanded and the high-side request is off, clamp_gate_o is driven. hs_gate_o and clamp_gate_o are never high together.
- R6: hs_gate_o falls two clock edges after a code at the upper level is presented. Exactly two cycles with both gates low separate a high-side fall from the next clamp rise. The same two-cycle gap separates a clamp fall from the next high-side rise.
- R7: In counting mode, the dwell count is loaded from the dwell register while idle. While commanded, each rising edge of phase_pin_i, passed through a two-stage synchronizer, decrements the count at the third clock edge after the pin rises. The peak pair is used while the count is non-zero and the hold pair once it reaches zero. Further pin edges do not change the phase.
- R8: In level mode (address 1, data bit 3 = 1), a high phase_pin_i selects the peak pair and a low one selects the hold pair. The change appears two clock edges after the pin changes.
- R9: A dwell value of 0 in counting mode selects the hold pair from the start of the command.
- R10: When the command drops, the controller returns to idle with the dwell count reloaded, the peak pair armed and the high-side request on. The next command therefore drives hs_gate_o at its first clock edge when the current code is below the lower level.
- R11: Configuration writes take effect at the clock edge where cfg_we_i is high. The map is: address 1 bit 3 = mode; 2 = peak upper; 3 = peak lower; 4 = hold upper; 5 = hold lower (each of addresses 2 to 5 takes data bits 6:0); 6 = dwell (data bits 7:0). Writes to addresses 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable, ANDed with ctrl_i to form the command |
| ctrl_i | input | 1 | Regulation cycle control, ANDed with en_i |
| phase_pin_i | input | 1 | Asynchronous phase pin: dwell clock or direct pair select |
| cur_i | input | 7 | Sampled load-current code |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| hs_gate_o | output | 1 | High-side gate command |
| clamp_gate_o | output | 1 | Clamp gate command |
| loop_o | output | 1 | Loop state: 1 when current is at or above the reference |
| phase_peak_o | output | 1 | 1 while the peak threshold pair is in force |

## Verification
Four properties are checked on every cycle:
- the two gate commands never overlap;
- the two-cycle gap is kept in both switching directions;
- the high-side request obeys the upper and lower levels one edge later, and the dwell count never climbs while commanded;
- a mode write lands in the mode bit.

Some behaviours only directed scenarios can show:
- the full peak-to-hold sequence counted out on pin edges;
- the direct level selection with its synchronizer latency;
- a dwell of zero;
- the same-cycle shutdown and re-arming when the command drops;
- writes to unmapped addresses being ignored.

// File: rtl/ph_pkg.sv
`timescale 1ns/1ps
package ph_pkg;
    localparam int CUR_W        = 7;
    localparam int DWELL_W      = 8;
    localparam int CFG_AW       = 3;
    localparam int CFG_DW       = 8;
    localparam int AUX_MODE_BIT = 3;

    localparam logic [CFG_AW-1:0] ADR_AUX    = 3'd1;
    localparam logic [CFG_AW-1:0] ADR_PK_HI  = 3'd2;
    localparam logic [CFG_AW-1:0] ADR_PK_LO  = 3'd3;
    localparam logic [CFG_AW-1:0] ADR_HD_HI  = 3'd4;
    localparam logic [CFG_AW-1:0] ADR_HD_LO  = 3'd5;
    localparam logic [CFG_AW-1:0] ADR_DWELL  = 3'd6;

    typedef logic [CUR_W-1:0]   cur_t;
    typedef logic [DWELL_W-1:0] dwell_t;

    typedef struct packed {
        cur_t hi;
        cur_t lo;
    } thr_pair_t;

    typedef struct packed {
        logic      lvl_mode;
        thr_pair_t peak;
        thr_pair_t hold;
        dwell_t    dwell;
    } cfg_t;

    typedef enum logic [1:0] {
        DT_OFF = 2'd0,
        DT_HS  = 2'd1,
        DT_CL  = 2'd2
    } dt_state_e;

    localparam cfg_t CFG_RST = '{
        lvl_mode: 1'b0,
        peak:     '{hi: cur_t'(100), lo: cur_t'(90)},
        hold:     '{hi: cur_t'(40),  lo: cur_t'(30)},
        dwell:    dwell_t'(4)
    };

    function automatic thr_pair_t pick_pair(input logic use_peak, input cfg_t c);
        return use_peak ? c.peak : c.hold;
    endfunction
endpackage

// File: rtl/ph_cfg_regs.sv
`timescale 1ns/1ps
module ph_cfg_regs
    import ph_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [CFG_AW-1:0] addr_i,
    input  logic [CFG_DW-1:0] wdata_i,
    output cfg_t              cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else if (we_i) begin
            case (addr_i)
                ADR_AUX:   cfg_q.lvl_mode <= wdata_i[AUX_MODE_BIT];
                ADR_PK_HI: cfg_q.peak.hi  <= wdata_i[CUR_W-1:0];
                ADR_PK_LO: cfg_q.peak.lo  <= wdata_i[CUR_W-1:0];
                ADR_HD_HI: cfg_q.hold.hi  <= wdata_i[CUR_W-1:0];
                ADR_HD_LO: cfg_q.hold.lo  <= wdata_i[CUR_W-1:0];
                ADR_DWELL: cfg_q.dwell    <= wdata_i[DWELL_W-1:0];
                default:   ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    AST_AUX_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADR_AUX) |=> (cfg_q.lvl_mode == $past(wdata_i[AUX_MODE_BIT]))); // R11
endmodule

// File: rtl/ph_phase_sel.sv
`timescale 1ns/1ps
module ph_phase_sel
    import ph_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_i,
    input  logic   lvl_mode_i,
    input  dwell_t dwell_i,
    input  logic   pin_i,
    output logic   peak_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               pin_s;
    logic               pin_rise;
    dwell_t             cnt_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
    end

    assign pin_s    = chain_q[SYNC_STAGES-1];
    assign pin_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CFG_RST.dwell;
        end else if (!cmd_i) begin
            cnt_q <= dwell_i;
        end else if (pin_rise && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    generate
        if (SYNC_STAGES > 0) begin : g_sel
            assign peak_o = lvl_mode_i ? pin_s : (cnt_q != '0);
        end
    endgenerate

    AST_DWELL_NEVER_CLIMBS: assert property (@(posedge clk) disable iff (rst)
        (cmd_i && $past(cmd_i)) |-> (cnt_q <= $past(cnt_q))); // R7
endmodule

// File: rtl/ph_hyst.sv
`timescale 1ns/1ps
module ph_hyst
    import ph_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_i,
    input  cur_t      cur_i,
    input  thr_pair_t pair_i,
    output logic      hs_req_o,
    output logic      loop_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst || !cmd_i) begin
            req_q <= 1'b1;
        end else if (cur_i >= pair_i.hi) begin
            req_q <= 1'b0;
        end else if (cur_i < pair_i.lo) begin
            req_q <= 1'b1;
        end
    end

    always_comb begin
        if (req_q) loop_o = (cur_i >= pair_i.hi);
        else       loop_o = (cur_i >= pair_i.lo);
    end

    assign hs_req_o = req_q;

    AST_REQ_OFF_AT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (cmd_i && cur_i >= pair_i.hi) |=> !req_q); // R3
    AST_REQ_ON_BELOW_LOWER: assert property (@(posedge clk) disable iff (rst)
        (cmd_i && cur_i < pair_i.lo && cur_i < pair_i.hi) |=> req_q); // R3
endmodule

// File: rtl/ph_deadtime.sv
`timescale 1ns/1ps
module ph_deadtime
    import ph_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_i,
    input  logic hs_req_i,
    output logic hs_gate_o,
    output logic clamp_gate_o
);
    localparam int              GAP_W    = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(DEAD_CYC - 1);

    dt_state_e        st_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !cmd_i) begin
            st_q  <= DT_OFF;
            gap_q <= '0;
        end else begin
            case (st_q)
                DT_HS: begin
                    if (!hs_req_i) begin
                        st_q  <= DT_OFF;
                        gap_q <= GAP_LOAD;
                    end
                end
                DT_CL: begin
                    if (hs_req_i) begin
                        st_q  <= DT_OFF;
                        gap_q <= GAP_LOAD;
                    end
                end
                default: begin
                    if (gap_q != '0) gap_q <= gap_q - 1'b1;
                    else             st_q  <= hs_req_i ? DT_HS : DT_CL;
                end
            endcase
        end
    end

    assign hs_gate_o    = cmd_i && (st_q == DT_HS);
    assign clamp_gate_o = cmd_i && (st_q == DT_CL);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate_o && clamp_gate_o)); // R5
    AST_GAP_HS_TO_CL: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_gate_o) |-> (!$past(hs_gate_o) && !$past(hs_gate_o, 2))); // R6
    AST_GAP_CL_TO_HS: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate_o) |-> (!$past(clamp_gate_o) && !$past(clamp_gate_o, 2))); // R6
endmodule

// File: rtl/ph_regulator.sv
`timescale 1ns/1ps
module ph_regulator
    import ph_pkg::*;
#(
    parameter int DEAD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              ctrl_i,
    input  logic              phase_pin_i,
    input  logic [CUR_W-1:0]  cur_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic              hs_gate_o,
    output logic              clamp_gate_o,
    output logic              loop_o,
    output logic              phase_peak_o
);
    cfg_t      cfg;
    thr_pair_t pair;
    logic      cmd;
    logic      peak;
    logic      hs_req;

    assign cmd = en_i & ctrl_i;

    ph_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    ph_phase_sel #(.SYNC_STAGES(SYNC_STAGES)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .lvl_mode_i (cfg.lvl_mode),
        .dwell_i    (cfg.dwell),
        .pin_i      (phase_pin_i),
        .peak_o     (peak)
    );

    assign pair = pick_pair(peak, cfg);

    ph_hyst u_hyst (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .cur_i    (cur_i),
        .pair_i   (pair),
        .hs_req_o (hs_req),
        .loop_o   (loop_o)
    );

    ph_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .hs_req_i     (hs_req),
        .hs_gate_o    (hs_gate_o),
        .clamp_gate_o (clamp_gate_o)
    );

    assign phase_peak_o = peak;
endmodule

// File: tb/ph_regulator_bench.sv
`timescale 1ns/1ps
module ph_regulator_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, ctrl = 1'b0, pin = 1'b0;
    logic [6:0] cur = 7'd0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       hs, cl, loopv, peak;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ph_regulator u_ph_regulator (
        .clk (clk), .rst (rst), .en_i (en), .ctrl_i (ctrl), .phase_pin_i (pin),
        .cur_i (cur), .cfg_we_i (we), .cfg_addr_i (addr), .cfg_wdata_i (wdata),
        .hs_gate_o (hs), .clamp_gate_o (cl), .loop_o (loopv), .phase_peak_o (peak)
    );

    // {en, ctrl, pin, cur[6:0], exp hs, exp clamp, exp loop, exp peak}
    localparam int NVEC = 23;
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {3'b000, 7'd0,   4'b0001},  // idle (R2)
        {3'b100, 7'd0,   4'b0001},  // en alone (R2)
        {3'b010, 7'd0,   4'b0001},  // ctrl alone (R2)
        {3'b110, 7'd50,  4'b1001},
        {3'b110, 7'd95,  4'b1001},  // inside band, keep on
        {3'b110, 7'd100, 4'b0111},  // reach upper
        {3'b110, 7'd95,  4'b0111},  // inside band, keep off
        {3'b110, 7'd89,  4'b1001},  // below lower
        {3'b110, 7'd127, 4'b0111},
        {3'b111, 7'd127, 4'b0111},  // pin edge 1
        {3'b110, 7'd127, 4'b0111},
        {3'b111, 7'd127, 4'b0111},  // pin edge 2
        {3'b110, 7'd127, 4'b0111},
        {3'b111, 7'd127, 4'b0111},  // pin edge 3
        {3'b110, 7'd127, 4'b0111},
        {3'b111, 7'd127, 4'b0110},  // pin edge 4: hold (R7)
        {3'b110, 7'd35,  4'b0110},
        {3'b110, 7'd20,  4'b1000},
        {3'b110, 7'd39,  4'b1000},
        {3'b111, 7'd39,  4'b1000},  // extra edge, stays hold (R7)
        {3'b100, 7'd39,  4'b0001},  // drop: re-armed peak (R10)
        {3'b110, 7'd39,  4'b1001},
        {3'b100, 7'd39,  4'b0001}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1);
        chk("R1", "hs after reset", hs, 1'b0);
        chk("R1", "clamp after reset", cl, 1'b0);
        chk("R1", "loop after reset", loopv, 1'b0);
        chk("R1", "peak after reset", peak, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            en = VEC[i][13]; ctrl = VEC[i][12]; pin = VEC[i][11]; cur = VEC[i][10:4];
            step(6);
            chk("R3", $sformatf("vec %0d hs", i), hs, VEC[i][3]);
            chk("R5", $sformatf("vec %0d clamp", i), cl, VEC[i][2]);
            chk("R4", $sformatf("vec %0d loop", i), loopv, VEC[i][1]);
            chk("R7", $sformatf("vec %0d peak", i), peak, VEC[i][0]);
        end

        // R6: high-side to clamp gap
        pin = 1'b0; ctrl = 1'b1; cur = 7'd0;
        step(6);
        chk("R3", "hs on before gap test", hs, 1'b1);
        cur = 7'd110;
        step(1); chk("R6", "hs e1", hs, 1'b1); chk("R6", "clamp e1", cl, 1'b0);
        step(1); chk("R6", "hs e2", hs, 1'b0); chk("R6", "clamp e2", cl, 1'b0);
        step(1); chk("R6", "hs e3", hs, 1'b0); chk("R6", "clamp e3", cl, 1'b0);
        step(1); chk("R6", "clamp e4", cl, 1'b1);
        // R6: clamp to high-side gap
        cur = 7'd0;
        step(1); chk("R6", "clamp back e1", cl, 1'b1); chk("R6", "hs back e1", hs, 1'b0);
        step(1); chk("R6", "clamp back e2", cl, 1'b0); chk("R6", "hs back e2", hs, 1'b0);
        step(1); chk("R6", "hs back e3", hs, 1'b0);
        step(1); chk("R6", "hs back e4", hs, 1'b1);

        // R2: same-cycle shutdown
        ctrl = 1'b0;
        #1 chk("R2", "hs immediate off", hs, 1'b0);
        chk("R2", "clamp immediate off (hs case)", cl, 1'b0);
        @(negedge clk);
        ctrl = 1'b1; cur = 7'd110;
        step(8);
        chk("R5", "clamp driven", cl, 1'b1);
        en = 1'b0;
        #1 chk("R2", "clamp immediate off", cl, 1'b0);
        chk("R2", "hs stays off", hs, 1'b0);
        @(negedge clk);
        step(2);
        chk("R10", "peak re-armed", peak, 1'b1);
        cur = 7'd0; en = 1'b1;
        step(1);
        chk("R10", "hs at first edge", hs, 1'b1);
        en = 1'b0;

        // R8: level mode
        wr(3'd1, 8'h08);
        step(3);
        chk("R8", "pin low gives hold", peak, 1'b0);
        pin = 1'b1;
        step(1); chk("R8", "sync latency", peak, 1'b0);
        step(1); chk("R8", "pin high gives peak", peak, 1'b1);
        en = 1'b1; cur = 7'd50;
        step(8);
        chk("R8", "peak pair drives hs", hs, 1'b1);
        pin = 1'b0;
        step(8);
        chk("R8", "hold pair drives clamp", cl, 1'b1);
        chk("R8", "hold selected", peak, 1'b0);
        en = 1'b0;

        // R9: zero dwell
        wr(3'd1, 8'h00);
        wr(3'd6, 8'h00);
        step(2);
        chk("R9", "zero dwell idle hold", peak, 1'b0);
        en = 1'b1; cur = 7'd45;
        step(8);
        chk("R9", "zero dwell clamp", cl, 1'b1);
        chk("R9", "zero dwell hold", peak, 1'b0);
        en = 1'b0;

        // R11: unmapped writes ignored, threshold writes masked to 7 bits
        wr(3'd0, 8'hFF);
        wr(3'd7, 8'hFF);
        wr(3'd6, 8'h04);
        step(2);
        chk("R11", "mode unchanged by unmapped writes", peak, 1'b1);
        wr(3'd2, 8'h94);
        wr(3'd3, 8'd10);
        en = 1'b1; cur = 7'd25;
        step(8);
        chk("R11", "new upper turns hs off", hs, 1'b0);
        chk("R11", "new upper drives clamp", cl, 1'b1);
        chk("R11", "loop vs new lower", loopv, 1'b1);
        chk("R11", "still peak", peak, 1'b1);
        en = 1'b0;
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule